// File: doc/BRIEF.md
# Dual-Mode Serial Port Interrupt Enable and Request Logic

This block holds the interrupt-enable register of a serial port and turns the port's event conditions into a single interrupt request. Software reaches the register through a small byte-wide register port. A mode input chooses between legacy operation and extended operation. In legacy mode only the lower four enable bits can be held. The two upper functional enables, transmitter-empty and DMA, exist only in extended mode.

Raw conditions come in from the receiver, the transmitter, the FIFO level logic, the modem-status and link-status logic, and the DMA engine. They are merged into six events. The events are registered into a flag vector that software can observe. Each event is also masked by its enable bit, and the OR of the masked events drives a registered interrupt output.

Top module: `uart_irq_enable`

## Requirements
- R1: After the active-low asynchronous reset the enable register is 00h, and irq_o and evt_flags_o are all zero.
- R2: The enable register sits at address 1. With rd_en_i high and addr_i equal to 1, rdata_o returns the enable bits in [5:0], and bits [7:6] always read 0; written values of bits [7:6] are ignored. At any other address, or with rd_en_i low, rdata_o is 00h. A read never changes evt_flags_o.
- R3: Enable bits 5 and 4 can be written only while ext_mode_i is 1. A write while ext_mode_i is 0 leaves them 0. When ext_mode_i is 0 at a clock edge, both bits are cleared on that edge, and their sources stop driving irq_o on that same edge.
- R4: The bit assignment of the enable register and of evt_flags_o is: 0 receive-high-level, 1 transmit-low-level, 2 link-status or transmitter-halted, 3 modem-status, 4 DMA terminal count, 5 transmitter empty.
- R5: The receive-high-level event is true when the receive holding register is full, or when rx_lvl_i >= rx_thr_i, or when rx_tmo_i is high.
- R6: The transmit-low-level event is true when tx_lvl_i < tx_thr_i or when the transmit holding register is empty.
- R7: The DMA event is true only when dma_tc_i and dma_en_i are both high.
- R8: irq_o is a register that holds the OR over all bits of (event AND effective enable), sampled at the previous clock edge.
- R9: evt_flags_o is a register that holds the six events sampled at the previous clock edge, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| ext_mode_i | input | 1 | Extended mode select |
| rx_hold_full_i | input | 1 | Receive holding register full |
| rx_lvl_i | input | 5 | RX FIFO fill count |
| rx_thr_i | input | 5 | RX FIFO threshold |
| rx_tmo_i | input | 1 | RX FIFO timeout |
| tx_lvl_i | input | 5 | TX FIFO fill count |
| tx_thr_i | input | 5 | TX FIFO threshold |
| tx_hold_empty_i | input | 1 | Transmit holding register empty |
| tx_empty_i | input | 1 | Transmitter fully empty |
| tx_halt_i | input | 1 | Transmitter halted |
| link_stat_i | input | 1 | Link status event |
| modem_stat_i | input | 1 | Modem status event |
| dma_en_i | input | 1 | DMA enabled |
| dma_tc_i | input | 1 | DMA terminal count |
| evt_flags_o | output | 6 | Registered event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Two actions can fall in the same clock edge: the drop of extended mode, and a register write of the upper enables while the transmitter-empty event is active and enabled. The bench drives ext_mode_i low in the same cycle as a write of 3Fh. The register must then read 0Fh and the request must fall on that edge. A behavioural reference model is compared on every clock and judges this cycle alongside the directed checks.

// File: rtl/uie_pkg.sv
package uie_pkg;
  localparam int SRC_N   = 6;
  localparam int B_RXHI  = 0;
  localparam int B_TXLO  = 1;
  localparam int B_LINK  = 2;
  localparam int B_MODEM = 3;
  localparam int B_DMA   = 4;
  localparam int B_TXEMP = 5;
  localparam int EXT_LO  = 4;  // lowest extended-only enable
  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/uie_reg.sv
module uie_reg
  import uie_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int OFS    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ext_mode_i,
  output src_vec_t          en_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(OFS);

  src_vec_t en_q, en_d;
  logic     wr_hit, rd_hit;
  logic     unused_wbits;

  assign wr_hit = wr_en_i && (addr_i == OFS_A);
  assign rd_hit = rd_en_i && (addr_i == OFS_A);
  assign unused_wbits = ^wdata_i[DATA_W-1:SRC_N];

  always_comb begin
    en_d = en_q;
    if (wr_hit) en_d = wdata_i[SRC_N-1:0];
    if (!ext_mode_i) en_d[SRC_N-1:EXT_LO] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  assign en_o    = en_q;
  assign rdata_o = rd_hit ? DATA_W'(en_q) : '0;
endmodule

// File: rtl/uie_evt.sv
module uie_evt
  import uie_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_hold_full_i,
  input  logic [CNT_W-1:0] rx_lvl_i,
  input  logic [CNT_W-1:0] rx_thr_i,
  input  logic             rx_tmo_i,
  input  logic [CNT_W-1:0] tx_lvl_i,
  input  logic [CNT_W-1:0] tx_thr_i,
  input  logic             tx_hold_empty_i,
  input  logic             tx_empty_i,
  input  logic             tx_halt_i,
  input  logic             link_stat_i,
  input  logic             modem_stat_i,
  input  logic             dma_en_i,
  input  logic             dma_tc_i,
  output src_vec_t         evt_o,
  output src_vec_t         flg_o
);
  src_vec_t flg_q;

  always_comb begin
    evt_o          = '0;
    evt_o[B_RXHI]  = rx_hold_full_i | (rx_lvl_i >= rx_thr_i) | rx_tmo_i;
    evt_o[B_TXLO]  = (tx_lvl_i < tx_thr_i) | tx_hold_empty_i;
    evt_o[B_LINK]  = link_stat_i | tx_halt_i;
    evt_o[B_MODEM] = modem_stat_i;
    evt_o[B_DMA]   = dma_tc_i & dma_en_i;
    evt_o[B_TXEMP] = tx_empty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= evt_o;
  end

  assign flg_o = flg_q;
endmodule

// File: rtl/uie_irq.sv
module uie_irq
  import uie_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t en_i,
  input  logic     ext_mode_i,
  output logic     irq_o
);
  src_vec_t hit;
  logic     irq_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    if (g >= EXT_LO) begin : g_ext
      assign hit[g] = evt_i[g] & en_i[g] & ext_mode_i;
    end else begin : g_base
      assign hit[g] = evt_i[g] & en_i[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uie_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int OFS    = 1,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ext_mode_i,
  input  logic              rx_hold_full_i,
  input  logic [CNT_W-1:0]  rx_lvl_i,
  input  logic [CNT_W-1:0]  rx_thr_i,
  input  logic              rx_tmo_i,
  input  logic [CNT_W-1:0]  tx_lvl_i,
  input  logic [CNT_W-1:0]  tx_thr_i,
  input  logic              tx_hold_empty_i,
  input  logic              tx_empty_i,
  input  logic              tx_halt_i,
  input  logic              link_stat_i,
  input  logic              modem_stat_i,
  input  logic              dma_en_i,
  input  logic              dma_tc_i,
  output logic [SRC_N-1:0]  evt_flags_o,
  output logic              irq_o
);
  src_vec_t en_q, evt;

  uie_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS(OFS)) i_reg (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .ext_mode_i,
    .en_o(en_q), .rdata_o
  );

  uie_evt #(.CNT_W(CNT_W)) i_evt (
    .clk_i, .rst_ni, .rx_hold_full_i, .rx_lvl_i, .rx_thr_i, .rx_tmo_i,
    .tx_lvl_i, .tx_thr_i, .tx_hold_empty_i, .tx_empty_i, .tx_halt_i,
    .link_stat_i, .modem_stat_i, .dma_en_i, .dma_tc_i,
    .evt_o(evt), .flg_o(evt_flags_o)
  );

  uie_irq i_irq (
    .clk_i, .rst_ni, .evt_i(evt), .en_i(en_q), .ext_mode_i, .irq_o
  );
endmodule

// File: rtl/uie_chk.sv
module uie_chk
  import uie_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int OFS    = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ext_mode_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [SRC_N-1:0]  en_q,
  input logic [SRC_N-1:0]  evt_flags_o,
  input logic              irq_o
);
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:SRC_N] == '0);

  a_r2_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == ADDR_W'(OFS)) |-> rdata_o == '0);

  a_r3_upper_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_mode_i |=> en_q[SRC_N-1:EXT_LO] == '0);

  a_r8_irq_has_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> evt_flags_o != '0);

  a_r8_no_enable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q == '0 |=> !irq_o);
endmodule

bind uart_irq_enable uie_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS(OFS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_mode_i(ext_mode_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .en_q(en_q), .evt_flags_o(evt_flags_o),
  .irq_o(irq_o)
);

// File: tb/test_uart_irq_enable.sv
`timescale 1ns/1ps
module test_uart_irq_enable;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, ext = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rx_full = 0, rx_tmo = 0, tx_hold_e = 0, tx_empty = 0, tx_halt = 0;
  logic link = 0, modem = 0, dma_en = 0, dma_tc = 0;
  logic [4:0] rx_lvl = 0, rx_thr = 8, tx_lvl = 8, tx_thr = 4;
  logic [5:0] flags;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_enable i_uart_irq_enable (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_mode_i(ext), .rx_hold_full_i(rx_full),
    .rx_lvl_i(rx_lvl), .rx_thr_i(rx_thr), .rx_tmo_i(rx_tmo), .tx_lvl_i(tx_lvl),
    .tx_thr_i(tx_thr), .tx_hold_empty_i(tx_hold_e), .tx_empty_i(tx_empty),
    .tx_halt_i(tx_halt), .link_stat_i(link), .modem_stat_i(modem),
    .dma_en_i(dma_en), .dma_tc_i(dma_tc), .evt_flags_o(flags), .irq_o(irq)
  );

  // behavioural reference model
  int m_en = 0, m_flags = 0, m_irq = 0;

  function automatic int model_evt();
    int e = 0;
    if (rx_full || int'(rx_lvl) >= int'(rx_thr) || rx_tmo) e += 1;
    if (int'(tx_lvl) < int'(tx_thr) || tx_hold_e) e += 2;
    if (link || tx_halt) e += 4;
    if (modem) e += 8;
    if (dma_tc && dma_en) e += 16;
    if (tx_empty) e += 32;
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_flags = 0; m_irq = 0;
    end else begin
      int e, eff, nen;
      e = model_evt();
      eff = ext ? m_en : (m_en % 16);
      nen = m_en;
      if (wr_en && addr == 1) nen = int'(wdata) % 64;
      if (!ext) nen = nen % 16;
      m_irq = ((e & eff) != 0) ? 1 : 0;
      m_flags = e;
      m_en = nen;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int exp_rd;
    exp_rd = (rd_en && addr == 1) ? m_en : 0;
    chk(int'(irq) == m_irq, "R8 model irq", int'(irq), m_irq);
    chk(int'(flags) == m_flags, "R9 model flags", int'(flags), m_flags);
    chk(int'(rdata) == exp_rd, "R2 model rdata", int'(rdata), exp_rd);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; addr = 1; wdata = d;
    tick();
    wr_en = 0; addr = 0;
  endtask

  task automatic rd_chk(int exp, string req);
    rd_en = 1; addr = 1; #1;
    chk(int'(rdata) == exp, req, int'(rdata), exp);
    rd_en = 0; addr = 0;
  endtask

  task automatic set_evt(int b, logic v);
    case (b)
      0: rx_full = v;
      1: tx_hold_e = v;
      2: link = v;
      3: modem = v;
      4: begin dma_en = 1; dma_tc = v; end
      default: tx_empty = v;
    endcase
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(irq == 0, "R1 irq", int'(irq), 0);
    chk(flags == 0, "R1 flags", int'(flags), 0);
    rd_chk(0, "R1 enable reset");

    // R2 reserved bits, R3 extended write
    ext = 1; tick();
    wr(8'hFF);
    rd_chk('h3F, "R2 reserved read zero");
    addr = 3; rd_en = 1; #1;
    chk(rdata == 0, "R2 other address", int'(rdata), 0);
    rd_en = 0; addr = 0;
    ext = 0; tick();
    rd_chk('h0F, "R3 mode drop clears upper");
    wr(8'h30);
    rd_chk(0, "R3 upper write ignored non-ext");

    // R4 each enable bit asserts and deasserts irq
    ext = 1;
    for (int b = 0; b < 6; b++) begin
      wr(8'(1 << b));
      set_evt(b, 1); tick();
      chk(irq == 1, "R4 bit asserts", int'(irq), 1);
      chk(flags[b] == 1, "R9 flag set", int'(flags), 1 << b);
      set_evt(b, 0); tick();
      chk(irq == 0, "R4 bit deasserts", int'(irq), 0);
      for (int o = 0; o < 6; o++) if (o != b) set_evt(o, 1);
      tick();
      chk(irq == 0, "R8 other sources masked", int'(irq), 0);
      for (int o = 0; o < 6; o++) if (o != b) set_evt(o, 0);
      dma_en = 0;
      tick();
    end

    // R5 receive-high merge and threshold boundary
    wr(8'h01);
    rx_lvl = 7; rx_thr = 8; tick();
    chk(irq == 0, "R5 below threshold", int'(irq), 0);
    rx_lvl = 8; tick();
    chk(irq == 1, "R5 at threshold", int'(irq), 1);
    rx_lvl = 0; rx_tmo = 1; tick();
    chk(flags[0] == 1, "R5 timeout", int'(flags), 1);
    rx_tmo = 0; tick();

    // R6 transmit-low boundary
    wr(8'h02);
    tx_lvl = 4; tx_thr = 4; tick();
    chk(irq == 0, "R6 at threshold no event", int'(irq), 0);
    tx_lvl = 3; tick();
    chk(irq == 1, "R6 below threshold", int'(irq), 1);
    tx_lvl = 8; tick();

    // R7 terminal count without DMA enabled
    wr(8'h10);
    dma_en = 0; dma_tc = 1; tick();
    chk(flags[4] == 0 && irq == 0, "R7 tc gated", int'({irq, flags}), 0);
    dma_tc = 0; tick();

    // R2 read does not disturb flags
    modem = 1; tick();
    rd_en = 1; addr = 1; tick();
    chk(flags == 6'h08, "R2 read no side effect", int'(flags), 'h08);
    rd_en = 0; addr = 0; modem = 0; tick();

    // R3 mode drop in same cycle as upper write with active source
    wr(8'h20);
    tx_empty = 1; tick();
    chk(irq == 1, "R3 txemp before drop", int'(irq), 1);
    ext = 0; wr_en = 1; addr = 1; wdata = 8'h3F; tick();
    wr_en = 0; addr = 0;
    chk(irq == 0, "R3 irq falls with mode drop", int'(irq), 0);
    rd_chk('h0F, "R3 concurrent write lower only");
    tx_empty = 0; tick(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule